// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Timing

This block buffers data words between two unrelated clock domains. A producer pushes words on its own write clock and a consumer pulls them on its own read clock; neither clock's frequency is constrained relative to the other. Write and read pointers are kept in binary inside their own domain and pass to the other domain as Gray codes through two-flop synchronizers. The full condition is therefore computed on the write side and the empty condition on the read side.

The timing mode is captured when master reset ends. In standard timing, a word reaches the data output only when the consumer asks for it with a read strobe. In fall-through timing, the oldest stored word is moved into the output register without a strobe, so the consumer sees data together with a ready indication. In that case the strobe only takes the presented word away. The two status outputs change meaning with the mode. A partial reset empties the FIFO in mid-operation and keeps the selected mode, so the surrounding logic does not have to configure it again.

Top module: `dcfifo_ft`

## Requirements
- R1: A word on `din` is stored at a rising `wclk` edge where `wen_n` is 0, unless the FIFO is full. A write attempted while full is dropped, and no stored word is lost or overwritten.
- R2: A read happens at a rising `rclk` edge where `ren_n` is 0 and stored data exists. A read attempted with nothing stored leaves `dout` unchanged.
- R3: In standard timing (mode 0), a word written into an empty FIFO does not appear on `dout` until a read. `dout` keeps its value while `ren_n` is 1.
- R4: In fall-through timing (mode 1), the first word written into an empty FIFO appears on `dout`, with `ef_or` = 1, at the third rising `rclk` edge after the write edge, without any read strobe. While `ren_n` stays 1, that word and `ef_or` are held. A later word replaces it only after a read.
- R5: In mode 0, `ef_or` = 1 means the FIFO is empty and `ff_ir` = 1 means it is full. In mode 1, `ef_or` = 1 means `dout` holds a valid unread word, and `ff_ir` = 1 means a write would be accepted.
- R6: In mode 0 the FIFO holds 2^AW words. In mode 1 it holds 2^AW + 1 words: the storage array plus the word waiting in the output register.
- R7: Master reset (`mrst_n` = 0) empties the FIFO and clears `dout` to 0. The `mode_sel` value present at the first rising `rclk` edge after `mrst_n` returns to 1 sets the mode (1 = fall-through). The mode then stays fixed until the next master reset.
- R8: Partial reset (`prst_n` = 0) empties the FIFO and clears `dout` and the output-valid state. The mode selected at the last master reset is kept.
- R9: `hf` is 1 exactly when the storage array holds more than 2^AW / 2 words, in both modes. In mode 1, the word waiting in the output register is not counted.
- R10: Words leave the FIFO in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, asynchronous assert |
| mode_sel | input | 1 | Timing mode sampled after master reset: 0 standard, 1 fall-through |
| wen_n | input | 1 | Write enable, active low |
| din | input | W | Write data |
| ren_n | input | 1 | Read enable, active low |
| dout | output | W | Read data register |
| ef_or | output | 1 | Empty (mode 0) or output ready (mode 1) |
| ff_ir | output | 1 | Full (mode 0) or input ready (mode 1) |
| hf | output | 1 | Storage array more than half occupied |

## Verification
Several internal faults show up at the ports quickly:
- A pointer that skips or repeats a location gives a wrong word at the very next read. The bench checks the data order at every fill level from one word to the full depth.
- A wrong full or empty comparison shows as a flag that is off at the exact write or read that crosses the boundary. This also makes an extra word appear or a valid word go missing during the following drain.
- An extra or missing synchronizer stage moves the fall-through arrival away from the third read edge. The bench counts those edges one by one.
- A mode register that is not retained across partial reset shows on the first word written afterwards, which fails to fall through.

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         mode_sel,
  input  logic         wen_n,
  input  logic [W-1:0] din,
  input  logic         ren_n,
  output logic [W-1:0] dout,
  output logic         ef_or,
  output logic         ff_ir,
  output logic         hf
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;
  localparam logic [AW:0] ONE = (AW+1)'(1);

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic          rst_n;
  logic          arm, fwft;
  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic [AW:0]   rbin, rgray, wq1, wq2;
  logic [AW:0]   wocc;
  logic          full, mem_empty, we, re, valid;

  assign rst_n = mrst_n & prst_n;

  // mode capture: armed through master reset, sampled once at the first edge after release
  always_ff @(posedge rclk or negedge mrst_n)
    if (!mrst_n) arm <= 1'b1;
    else         arm <= 1'b0;

  always_ff @(posedge rclk)
    if (arm) fwft <= mode_sel;

  // write domain
  assign full = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign we   = !wen_n && !full;
  assign wocc = wbin - g2b(rq2);
  assign hf   = wocc > (AW+1)'(HALF);

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (we) begin
        wbin  <= wbin + ONE;
        wgray <= b2g(wbin + ONE);
      end
    end

  always_ff @(posedge wclk)
    if (we) mem[wbin[AW-1:0]] <= din;

  // read domain
  assign mem_empty = (rgray == wq2);
  assign re = !mem_empty && (fwft ? (!valid || !ren_n) : !ren_n);

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (re) begin
        rbin  <= rbin + ONE;
        rgray <= b2g(rbin + ONE);
        dout  <= mem[rbin[AW-1:0]];
        valid <= 1'b1;
      end else if (!ren_n) begin
        valid <= 1'b0;
      end
    end

  assign ef_or = fwft ? valid : mem_empty;
  assign ff_ir = fwft ? !full : full;

  p_no_overflow_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> wbin == $past(wbin));

  p_no_underflow_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    mem_empty |=> rbin == $past(rbin));

  p_std_hold_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && !arm && ren_n) |=> $stable(dout));

  p_fwft_hold_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && !arm && valid && ren_n) |=> ($stable(dout) && valid));

  p_occ_bound_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    wocc <= (AW+1)'(DEPTH));

  p_mode_hold_r7: assert property (@(posedge rclk) disable iff (!mrst_n)
    !arm |=> $stable(fwft));

  p_gray_step_r10: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: tb/tb_dcfifo_ft.sv
`timescale 1ns/1ps
module tb_dcfifo_ft;
  localparam int W = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = DEPTH / 2;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 1, prst_n = 1, mode_sel = 0;
  logic wen_n = 1, ren_n = 1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic ef_or, ff_ir, hf;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 wclk = ~wclk;
  always #5 rclk = ~rclk;

  dcfifo_ft #(.W(W), .AW(AW)) dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .wen_n(wen_n), .din(din), .ren_n(ren_n), .dout(dout),
    .ef_or(ef_or), .ff_ir(ff_ir), .hf(hf));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_mrst(input logic m);
    @(negedge rclk);
    mrst_n = 0; mode_sel = m;
    repeat (3) @(negedge rclk);
    mrst_n = 1;
    @(negedge rclk);
    mode_sel = ~m;
    repeat (4) @(negedge wclk);
  endtask

  task automatic do_prst();
    @(negedge rclk);
    prst_n = 0;
    repeat (3) @(negedge rclk);
    prst_n = 1;
    repeat (2) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic wr(input logic [W-1:0] d);
    @(negedge wclk);
    wen_n = 0; din = d;
    @(negedge wclk);
    wen_n = 1;
  endtask

  task automatic rd();
    @(negedge rclk);
    ren_n = 0;
    @(negedge rclk);
    ren_n = 1;
  endtask

  function automatic logic [W-1:0] pat(input int n, input int i);
    return W'((n * 29 + i * 11 + 3) & 8'hFF);
  endfunction

  initial begin
    #400000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R10 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp_q [DEPTH+1];
    logic [W-1:0] last;
    int edges;

    // standard-mode reset state
    do_mrst(1'b0);
    chk("R7 reset dout", dout, 0);
    chk("R5 std empty after reset", ef_or, 1);
    chk("R5 std full after reset", ff_ir, 0);
    chk("R9 hf after reset", hf, 0);

    // R3: word not presented without read
    wr(8'hA7);
    repeat (6) @(negedge rclk);
    chk("R3 no presentation without read", dout, 0);
    chk("R5 std not empty", ef_or, 0);
    rd();
    chk("R3 word after read", dout, 8'hA7);
    chk("R5 std empty after last read", ef_or, 1);
    repeat (10) @(negedge wclk);

    // fill-level sweep in standard mode
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) begin
        wr(pat(n, i));
        chk($sformatf("R9 hf n=%0d i=%0d", n, i), hf, (i + 1 > HALF) ? 1 : 0);
      end
      chk($sformatf("R5 full flag n=%0d", n), ff_ir, (n == DEPTH) ? 1 : 0);
      if (n == DEPTH) begin
        wr(8'hEE);
        chk("R1 write while full keeps full", ff_ir, 1);
      end
      repeat (4) @(negedge rclk);
      for (int i = 0; i < n; i++) begin
        rd();
        chk($sformatf("R10 order n=%0d i=%0d", n, i), dout, pat(n, i));
      end
      chk($sformatf("R6 empty after %0d reads", n), ef_or, 1);
      last = pat(n, n - 1);
      rd();
      chk($sformatf("R2 read while empty n=%0d", n), dout, last);
      repeat (10) @(negedge wclk);
      chk($sformatf("R9 hf drained n=%0d", n), hf, 0);
    end

    // fall-through mode
    do_mrst(1'b1);
    chk("R7 fwft reset dout", dout, 0);
    chk("R5 fwft not ready", ef_or, 0);
    chk("R5 fwft input ready", ff_ir, 1);

    @(negedge wclk);
    wen_n = 0; din = 8'h5A;
    @(posedge wclk);
    fork begin @(negedge wclk); wen_n = 1; end join_none
    edges = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge rclk);
      edges++;
      @(negedge rclk);
      if (ef_or) break;
    end
    chk("R4 first word latency in rclk edges", edges, 3);
    chk("R4 first word value", dout, 8'h5A);
    exp_q[0] = 8'h5A;
    repeat (10) @(negedge wclk);

    for (int i = 1; i <= DEPTH; i++) begin
      exp_q[i] = pat(40, i);
      wr(exp_q[i]);
      chk($sformatf("R9 fwft hf array=%0d", i), hf, (i > HALF) ? 1 : 0);
    end
    chk("R6 fwft holds depth+1 (input not ready)", ff_ir, 0);
    wr(8'h11);
    chk("R1 write dropped when full", ff_ir, 0);
    repeat (8) @(negedge rclk);
    chk("R4 held without read", dout, 8'h5A);
    chk("R4 ready held", ef_or, 1);

    for (int i = 0; i <= DEPTH; i++) begin
      chk($sformatf("R10 fwft order i=%0d", i), dout, exp_q[i]);
      rd();
    end
    chk("R5 fwft not ready after drain", ef_or, 0);
    rd();
    chk("R2 fwft read while empty", ef_or, 0);

    // partial reset keeps mode
    wr(8'h21); wr(8'h22); wr(8'h23);
    repeat (8) @(negedge rclk);
    do_prst();
    chk("R8 prst dout cleared", dout, 0);
    chk("R8 prst not ready", ef_or, 0);
    chk("R8 prst input ready", ff_ir, 1);
    chk("R8 prst hf", hf, 0);
    wr(8'hC3);
    repeat (6) @(negedge rclk);
    chk("R8 mode kept: falls through", ef_or, 1);
    chk("R8 mode kept: value", dout, 8'hC3);

    // back to standard
    do_mrst(1'b0);
    chk("R7 std again empty", ef_or, 1);
    chk("R7 std again not full", ff_ir, 0);
    chk("R7 std again dout", dout, 0);
    wr(8'h77);
    repeat (6) @(negedge rclk);
    chk("R3 std mode restored", dout, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule